// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It divides the system clock into fixed 16-cycle conversion frames and produces the sample/hold window and a per-frame reset strobe. It steps a trial code onto the feedback DAC one bit at a time, starting with the most significant bit. It reads a single comparator bit back and uses it to settle each bit. After the eighth decision it hands out a registered result with a one-cycle done pulse.

The frame is timed by a chain of divide-by-two flops. The AND of their outputs marks one cycle in sixteen. That pulse resets the approximation register and is shifted through a one-hot strobe register. The strobe register sets every later phase of the frame: three sampling cycles, one hold-settle cycle, eight trial cycles, one latch cycle and the idle cycles that remain. At a 1 MHz clock this gives one conversion every 16 µs. The sample-and-hold, comparator and capacitor DAC sit outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: `frame_rst_o` is high for exactly one cycle in every 16. It is high during reset and in the first cycle after reset is released, and that cycle is slot 0 of the first frame. Slot s is the s-th cycle after a frame pulse.
- R2: `sh_en_o` is high in slots 1, 2 and 3 only.
- R3: `dac_code_o` is 8'h80 during reset and in slots 1 to 5 of every frame.
- R4: During the trial of bit b (slot 12−b, so bit 7 in slot 5 down to bit 0 in slot 12), bit b of `dac_code_o` is 1. The bits above b hold their decided values and the bits below b are 0.
- R5: At the end of each trial slot, `cmp_i` is sampled. A 0 clears the trial bit and a 1 keeps it. `cmp_i` has no effect on `dac_code_o` in any other slot, and the code stays at its final value through slots 13 to 15.
- R6: `result_o` changes only in slot 14. In that slot it takes the final code, and `done_o` is high for that one cycle only. `result_o` is 0 and `done_o` is low during reset.
- R7: With an ideal comparator (`cmp_i` high when the held input lies above the DAC level, the input sitting half an LSB above an integer code v), `result_o` equals v for every v from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator decision, high when the held input exceeds the DAC level |
| sh_en_o | output | 1 | Sample/hold enable, high while tracking the input |
| frame_rst_o | output | 1 | One-cycle frame pulse that resets the approximation register |
| dac_code_o | output | 8 | Trial code driven to the feedback DAC |
| result_o | output | 8 | Registered conversion result |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A divider or strobe-register fault moves the frame pulse or the sample window. That shows up within one frame, 16 cycles, as a wrong `frame_rst_o` or `sh_en_o` slot. A wrong approximation bit shows up in `dac_code_o` in the very next trial slot, before it reaches `result_o` two slots after the last trial. Outside the trial slots the bench drives random comparator values, so a decision taken in the wrong slot also corrupts the visible code at once.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    // Default geometry of one conversion frame.
    localparam int unsigned DEF_RES_BITS     = 8;
    localparam int unsigned DEF_DIV_STAGES   = 4;
    localparam int unsigned DEF_SAMPLE_SLOTS = 3;
endpackage

// File: rtl/sar_frame_div.sv
module sar_frame_div #(
    parameter int unsigned STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_o
);
    logic [STAGES-1:0] div_d, div_q;
    logic [STAGES:0]   carry;

    assign carry[0] = 1'b1;

    // Each stage halves the rate of the one below it.
    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            assign carry[k+1] = carry[k] & div_q[k];
        end
    endgenerate

    always_comb begin
        div_d = div_q ^ carry[STAGES-1:0];
    end

    // All ones at reset, so the frame pulse is present from the start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '1;
        else        div_q <= div_d;
    end

    assign frame_o = carry[STAGES];
endmodule

// File: rtl/sar_phase_shreg.sv
module sar_phase_shreg #(
    parameter int unsigned LEN = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_i,
    output logic [LEN-1:0] ph_o
);
    logic [LEN-1:0] ph_d, ph_q;

    // Bit k is high in slot k+1 of the frame.
    always_comb begin
        ph_d = {ph_q[LEN-2:0], frame_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign ph_o = ph_q;
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int unsigned RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           preset_i,
    input  logic [RES-1:0] trial_i,
    input  logic           latch_i,
    input  logic           cmp_i,
    output logic [RES-1:0] code_o,
    output logic [RES-1:0] result_o,
    output logic           done_o
);
    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    typedef struct packed {
        logic [RES-1:0] code;
        logic [RES-1:0] res;
        logic           done;
    } eng_t;

    eng_t st_d, st_q;
    logic [RES-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = trial_i & {RES{~cmp_i}};
        if (preset_i) begin
            st_d.code = MID;
        end else begin
            // Settle the current bit and arm the next lower one.
            st_d.code = (st_q.code & ~clr) | (trial_i >> 1);
        end
        st_d.done = latch_i;
        if (latch_i) st_d.res = st_q.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= MID;
            st_q.res  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o   = st_q.code;
    assign result_o = st_q.res;
    assign done_o   = st_q.done;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned RES_BITS     = DEF_RES_BITS,
    parameter int unsigned DIV_STAGES   = DEF_DIV_STAGES,
    parameter int unsigned SAMPLE_SLOTS = DEF_SAMPLE_SLOTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_i,
    output logic                sh_en_o,
    output logic                frame_rst_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);
    localparam int unsigned SETTLE_SLOT = SAMPLE_SLOTS + 1;
    localparam int unsigned TRIAL_BASE  = SAMPLE_SLOTS + 2;
    localparam int unsigned LATCH_SLOT  = TRIAL_BASE + RES_BITS;
    localparam int unsigned SR_LEN      = LATCH_SLOT;

    logic                frame;
    logic [SR_LEN-1:0]   ph;
    logic [RES_BITS-1:0] trial;
    logic                settle;
    logic                latch;

    sar_frame_div #(.STAGES(DIV_STAGES)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_o (frame)
    );

    sar_phase_shreg #(.LEN(SR_LEN)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame),
        .ph_o    (ph)
    );

    // Slot s maps to strobe bit s-1; the MSB is tried first.
    generate
        for (genvar j = 0; j < RES_BITS; j++) begin : g_trial
            assign trial[RES_BITS-1-j] = ph[TRIAL_BASE-1+j];
        end
    endgenerate

    assign settle = ph[SETTLE_SLOT-1];
    assign latch  = ph[LATCH_SLOT-1];

    sar_bit_engine #(.RES(RES_BITS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (frame | settle),
        .trial_i  (trial),
        .latch_i  (latch),
        .cmp_i    (cmp_i),
        .code_o   (dac_code_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign sh_en_o     = |ph[SAMPLE_SLOTS-1:0];
    assign frame_rst_o = frame;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int unsigned RES_BITS   = 8,
    parameter int unsigned DIV_STAGES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sh_en_o,
    input logic                frame_rst_o,
    input logic [RES_BITS-1:0] dac_code_o,
    input logic [RES_BITS-1:0] result_o,
    input logic                done_o
);
    localparam logic [DIV_STAGES-1:0] LAST = '1;
    localparam logic [RES_BITS-1:0]   MID  = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [DIV_STAGES-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           gap_q <= LAST;
        else if (frame_rst_o) gap_q <= '0;
        else                  gap_q <= gap_q + 1'b1;
    end

    assert_frame_on_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst_o |-> gap_q == LAST);
    assert_frame_not_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_rst_o |-> gap_q != LAST);
    assert_sample_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_en_o) |-> $past(frame_rst_o));
    assert_sample_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en_o |-> !frame_rst_o && !done_o);
    assert_code_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_rst_o) |-> dac_code_o == MID);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    assert_result_is_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> result_o == dac_code_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_BITS   (RES_BITS),
    .DIV_STAGES (DIV_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sh_en_o     (sh_en_o),
    .frame_rst_o (frame_rst_o),
    .dac_code_o  (dac_code_o),
    .result_o    (result_o),
    .done_o      (done_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
    localparam int FRAME = 16;
    localparam int NF    = 262;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp = 1'b0;
    logic       sh_en, frame_rst, done;
    logic [7:0] dac, result;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int vals[NF];
    int in_v  = 0;
    int held  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sar_conv_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_i       (cmp),
        .sh_en_o     (sh_en),
        .frame_rst_o (frame_rst),
        .dac_code_o  (dac),
        .result_o    (result),
        .done_o      (done)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d act=%0d exp=%0d", req, cyc, act, exp);
        end
    endtask

    // Code expected on the DAC in slot s of frame f.
    function automatic int exp_dac(int s, int f);
        int b;
        if (s == 0) return (f == 0) ? 128 : vals[f-1];
        if (s <= 4) return 128;
        if (s <= 12) begin
            b = 12 - s;
            return (vals[f] & ~((1 << (b + 1)) - 1)) | (1 << b);
        end
        return vals[f];
    endfunction

    function automatic string dac_req(int s);
        if (s >= 1 && s <= 5) return "R3";
        if (s >= 6 && s <= 12) return "R4";
        return "R5";
    endfunction

    // Track-and-hold model: follows the input while enabled.
    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (sh_en) held <= in_v;
        end
    end

    always @(negedge clk) begin
        int s, f;
        if (rst_n && !finished && cyc < NF * FRAME) begin
            s = cyc % FRAME;
            f = cyc / FRAME;
            chk("R1", int'(frame_rst), int'(s == 0));
            chk("R2", int'(sh_en), int'(s >= 1 && s <= 3));
            chk(dac_req(s), int'(dac), exp_dac(s, f));
            chk("R6", int'(done), int'(s == 14));
            if (s >= 14)     chk("R7", int'(result), vals[f]);
            else if (f == 0) chk("R6", int'(result), 0);
            else             chk("R6", int'(result), vals[f-1]);
            if (s == 0) in_v = vals[f];
            // Ideal comparator inside trials, random noise elsewhere.
            if (s >= 5 && s <= 12) cmp = (2 * held + 1) > (2 * int'(dac));
            else                   cmp = 1'($urandom % 2);
        end
    end

    initial begin
        vals[0] = 0;   vals[1] = 255; vals[2] = 128;
        vals[3] = 127; vals[4] = 1;   vals[5] = 254;
        for (int i = 0; i < 256; i++) vals[6 + i] = i;
        in_v = vals[0];
        repeat (3) @(negedge clk);
        // Reset state.
        chk("R1", int'(frame_rst), 1);
        chk("R2", int'(sh_en), 0);
        chk("R3", int'(dac), 128);
        chk("R6", int'(result), 0);
        chk("R6", int'(done), 0);
        rst_n = 1'b1;
        while (cyc < NF * FRAME) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, NF * FRAME);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule